// File: doc/BRIEF.md
# Nibble-Addressed BCD Calendar Clock

This block is a calendar clock. It holds the time and the date as packed decimal digits, one digit to each 4-bit register: seconds, minutes, hours, day of month, month, a two-digit year and a weekday. A host reads and writes the registers over a small parallel bus with a 4-bit address and a 4-bit data path. Writes are synchronous. Reads are combinational from the address. Three further registers hold the control state. The status register carries the freeze request, the update-in-progress bit, the interrupt flag and a rounding command. The rate register selects the periodic interrupt period and its output style. The mode register selects 12/24-hour operation and carries stop, reset and a test bit.

A prescaler outside the block supplies a one-clock strobe every second and a one-clock strobe at 64 Hz. Each applied second strobe advances the digit chain by one second, with carries through minutes, hours, day, month and year. A host that needs a coherent snapshot sets the freeze bit. It then reads or writes the digits while counting is held off, and clears the bit again. A second that arrives during the freeze is not lost: it is applied once the freeze ends.

Top module: `bcd_rtc`

## Requirements
- R1: After reset, registers 0x0 to 0xC read 0,0,0,0,0,0,1,0,1,0,0,0,0. This means 00:00:00, day 01, month 01, year 00 and weekday 0. The status register 0xD reads 0x0, the rate register 0xE reads 0x1 and the mode register 0xF reads 0x4.
- R2: The digit registers sit at 0x0 to 0xC in this order: seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens, day units, day tens, month units, month tens, year units, year tens, weekday. A written value reads back ANDed with a per-register mask. The mask is 0x7 for seconds tens, minutes tens, hours tens and weekday, 0x3 for day tens, 0x1 for month tens and 0xF for all the others. Bit 3 of the status register always reads 0.
- R3: Each applied second adds one to the seconds count. Units wrap from 9 to 0 into tens. Seconds 59 wrap to 00 and carry into minutes. Minutes 59 wrap to 00 and carry into the hour.
- R4: In 24-hour mode (mode bit 2 = 1), hour 23 wraps to 00 and advances the day. Each day advance steps the weekday 0..6, and 6 wraps to 0.
- R5: In 12-hour mode (mode bit 2 = 0), the hours run 12, 1, 2 … 11. Hours-tens bits [1:0] hold the tens digit and bit 2 is the PM flag (1 = PM). Passing from 11 to 12 toggles the PM flag. Passing from 11 PM to 12 AM advances the day.
- R6: The day wraps to 01 after the last day of the month and carries into the month. April, June, September and November have 30 days. February has 29 days when the year value is divisible by 4 and 28 otherwise. All other months have 31 days. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R7: While the freeze bit (status bit 0) is set, second strobes leave every digit unchanged. Any number of strobes during the freeze is remembered as one pending advance. That advance is applied in the first cycle after the freeze bit is cleared.
- R8: The busy bit (status bit 1) reads 1 exactly in the cycle in which a second is being applied, and 0 otherwise. A second strobe that coincides with a host write to a digit register is deferred by one cycle.
- R9: Writing 1 to status bit 3 rounds the time. If the seconds are 30 or more, the seconds become 00 and the minutes carry. Otherwise the seconds become 00 and the minutes stay. The bit reads back 0.
- R10: While the stop bit (mode bit 1) is set, no counting occurs and strobes are not remembered. While the reset bit (mode bit 0) is set, both seconds digits are held at 0, writes to them have no effect, and nothing counts.
- R11: Rate bits [3:2] select the event that sets the interrupt flag (status bit 2): 0 = each 64 Hz strobe, 1 = each applied second, 2 = each minute carry of an applied second, 3 = each hour carry of an applied second. Writing the status register with bit 2 = 0 clears the flag, and writing it with bit 2 = 1 leaves the flag as it is.
- R12: The interrupt output is low while rate bit 0 (mask) is 1. When unmasked with rate bit 1 = 1, the output follows the interrupt flag. With rate bit 1 = 0, the output is high for the one cycle after each selected event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickSec | input | 1 | One-cycle strobe once per second from the prescaler |
| tick64 | input | 1 | One-cycle strobe at 64 Hz from the prescaler |
| busAddr | input | 4 | Register address for reads and writes |
| busWrEn | input | 1 | Write enable, sampled on the rising clock edge |
| busWrData | input | 4 | Write data |
| busRdData | output | 4 | Read data for busAddr, combinational |
| irqOut | output | 1 | Periodic interrupt output |

## Verification
The carry chain is driven from start times that sit just before each boundary. These are a units wrap, 59-second and 59-minute carries, 23:59:59 in 24-hour mode, and 11 AM, 12 PM and 11 PM in 12-hour mode. This separates a wrong digit limit from a wrong carry path and from a wrong PM or day trigger. Month ends are tried for a 30-day month, February in a year not divisible by 4, February in a year divisible by 4 and the December/99 wrap, which separates the month table and the leap rule. The freeze, stop and reset cases send several strobes and then check that exactly one advance, or no advance, follows. The interrupt is tried at every rate from a state where a wrongly chosen source would fire one strobe early.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int NIB_W      = 4;
  localparam int ADDR_W     = 4;
  localparam int NUM_DIGITS = 13;
  localparam int NUM_REGS   = 2 ** ADDR_W;
  localparam int BIN_W      = 8;

  // digit register positions (host-visible order)
  localparam int IDX_SEC_U = 0;
  localparam int IDX_SEC_T = 1;
  localparam int IDX_MIN_U = 2;
  localparam int IDX_MIN_T = 3;
  localparam int IDX_HR_U  = 4;
  localparam int IDX_HR_T  = 5;
  localparam int IDX_DAY_U = 6;
  localparam int IDX_DAY_T = 7;
  localparam int IDX_MON_U = 8;
  localparam int IDX_MON_T = 9;
  localparam int IDX_YR_U  = 10;
  localparam int IDX_YR_T  = 11;
  localparam int IDX_WDAY  = 12;

  localparam logic [ADDR_W-1:0] ADR_STATUS = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] ADR_RATE   = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] ADR_MODE   = ADDR_W'(15);

  // strobes from control to datapath
  typedef struct packed {
    logic              advance;
    logic              round30;
    logic              clearSec;
    logic              mode24;
    logic              wrDigit;
    logic [ADDR_W-1:0] wrAddr;
    logic [NIB_W-1:0]  wrData;
  } dpCmd_t;

  // state hints from datapath back to control
  typedef struct packed {
    logic secAt59;
    logic minAt59;
  } dpStat_t;

  function automatic logic [NIB_W-1:0] digitMask(input int idx);
    case (idx)
      IDX_SEC_T, IDX_MIN_T, IDX_HR_T, IDX_WDAY: return NIB_W'(7);
      IDX_DAY_T:                                return NIB_W'(3);
      IDX_MON_T:                                return NIB_W'(1);
      default:                                  return NIB_W'(15);
    endcase
  endfunction

  function automatic logic [NIB_W-1:0] digitResetVal(input int idx);
    return (idx == IDX_DAY_U || idx == IDX_MON_U) ? NIB_W'(1) : NIB_W'(0);
  endfunction

  function automatic logic [BIN_W-1:0] bcdToBin(input logic [NIB_W-1:0] tens,
                                                 input logic [NIB_W-1:0] units);
    return BIN_W'(tens) * BIN_W'(10) + BIN_W'(units);
  endfunction

  function automatic logic [2*NIB_W-1:0] binToBcd(input logic [BIN_W-1:0] b);
    return {NIB_W'(b / BIN_W'(10)), NIB_W'(b % BIN_W'(10))};
  endfunction

  function automatic logic [BIN_W-1:0] monthLen(input logic [BIN_W-1:0] mon,
                                                 input logic [1:0] yrLow);
    case (mon)
      BIN_W'(4), BIN_W'(6), BIN_W'(9), BIN_W'(11): return BIN_W'(30);
      BIN_W'(2): return (yrLow == 2'd0) ? BIN_W'(29) : BIN_W'(28);
      default:   return BIN_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/bcd_rtc_ctrl.sv
module bcd_rtc_ctrl
  import bcd_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSec,
  input  logic              tick64,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [NIB_W-1:0]  busWrData,
  input  dpStat_t           stat,
  output dpCmd_t            cmd,
  output logic [NIB_W-1:0]  ctrlRd,
  output logic              irqOut
);
  logic       holdQ, irqFlagQ, pendingQ, pulseQ;
  logic [1:0] rateQ;
  logic       intModeQ, maskQ;
  logic       resetBitQ, stopQ, mode24Q, testQ;

  logic wrStatus, wrRate, wrMode, digitWr;
  logic runOk, round30, applyTick, periodEvt;

  assign wrStatus = busWrEn && (busAddr == ADR_STATUS);
  assign wrRate   = busWrEn && (busAddr == ADR_RATE);
  assign wrMode   = busWrEn && (busAddr == ADR_MODE);
  assign digitWr  = busWrEn && (busAddr < ADDR_W'(NUM_DIGITS));

  assign runOk     = !stopQ && !resetBitQ;
  assign round30   = wrStatus && busWrData[3] && !resetBitQ;
  assign applyTick = runOk && !holdQ && !digitWr && !round30 && (tickSec || pendingQ);

  always_comb begin
    case (rateQ)
      2'd0:    periodEvt = tick64 && runOk;
      2'd1:    periodEvt = applyTick;
      2'd2:    periodEvt = applyTick && stat.secAt59;
      default: periodEvt = applyTick && stat.secAt59 && stat.minAt59;
    endcase
  end

  // second bookkeeping: one remembered strobe while frozen or deferred
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
    end else if (applyTick) begin
      pendingQ <= 1'b0;
    end else if (runOk && tickSec) begin
      pendingQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ    <= 1'b0;
      irqFlagQ <= 1'b0;
      pulseQ   <= 1'b0;
    end else begin
      pulseQ <= periodEvt;
      if (wrStatus) holdQ <= busWrData[0];
      if (periodEvt) begin
        irqFlagQ <= 1'b1;
      end else if (wrStatus && !busWrData[2]) begin
        irqFlagQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateQ     <= 2'd0;
      intModeQ  <= 1'b0;
      maskQ     <= 1'b1;
      resetBitQ <= 1'b0;
      stopQ     <= 1'b0;
      mode24Q   <= 1'b1;
      testQ     <= 1'b0;
    end else begin
      if (wrRate) begin
        rateQ    <= busWrData[3:2];
        intModeQ <= busWrData[1];
        maskQ    <= busWrData[0];
      end
      if (wrMode) begin
        testQ     <= busWrData[3];
        mode24Q   <= busWrData[2];
        stopQ     <= busWrData[1];
        resetBitQ <= busWrData[0];
      end
    end
  end

  assign irqOut = !maskQ && (intModeQ ? irqFlagQ : pulseQ);

  always_comb begin
    case (busAddr)
      ADR_STATUS: ctrlRd = {1'b0, irqFlagQ, applyTick, holdQ};
      ADR_RATE:   ctrlRd = {rateQ, intModeQ, maskQ};
      ADR_MODE:   ctrlRd = {testQ, mode24Q, stopQ, resetBitQ};
      default:    ctrlRd = '0;
    endcase
  end

  always_comb begin
    cmd.advance  = applyTick;
    cmd.round30  = round30;
    cmd.clearSec = resetBitQ;
    cmd.mode24   = mode24Q;
    cmd.wrDigit  = digitWr;
    cmd.wrAddr   = busAddr;
    cmd.wrData   = busWrData;
  end
endmodule

// File: rtl/bcd_rtc_datapath.sv
module bcd_rtc_datapath
  import bcd_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [NIB_W-1:0]  digitRd,
  output dpStat_t           stat
);
  logic [NIB_W-1:0] digitQ    [NUM_DIGITS];
  logic [NIB_W-1:0] digitNext [NUM_DIGITS];
  logic [NIB_W-1:0] rdVec     [NUM_REGS];

  logic [BIN_W-1:0] secB, minB, hourB, dayB, monB, yearB, wdB;
  logic             pmQ;

  assign secB  = bcdToBin(digitQ[IDX_SEC_T], digitQ[IDX_SEC_U]);
  assign minB  = bcdToBin(digitQ[IDX_MIN_T], digitQ[IDX_MIN_U]);
  assign hourB = bcdToBin({2'b00, digitQ[IDX_HR_T][1:0]}, digitQ[IDX_HR_U]);
  assign dayB  = bcdToBin(digitQ[IDX_DAY_T], digitQ[IDX_DAY_U]);
  assign monB  = bcdToBin(digitQ[IDX_MON_T], digitQ[IDX_MON_U]);
  assign yearB = bcdToBin(digitQ[IDX_YR_T], digitQ[IDX_YR_U]);
  assign wdB   = BIN_W'(digitQ[IDX_WDAY]);
  assign pmQ   = digitQ[IDX_HR_T][2];

  assign stat.secAt59 = (secB >= BIN_W'(59));
  assign stat.minAt59 = (minB >= BIN_W'(59));

  logic             minInc, hourInc, dayInc, monInc, yearInc, nPm;
  logic [BIN_W-1:0] nSec, nMin, nHour, nDay, nMon, nYear, nWd, dayLimit;
  logic [2*NIB_W-1:0] bcdSec, bcdMin, bcdHour, bcdDay, bcdMon, bcdYear;

  always_comb begin
    minInc = (cmd.advance && secB >= BIN_W'(59)) ||
             (cmd.round30 && secB >= BIN_W'(30));
    nSec   = (cmd.round30 || secB >= BIN_W'(59)) ? '0 : secB + BIN_W'(1);

    hourInc = minInc && (minB >= BIN_W'(59));
    nMin    = minInc ? ((minB >= BIN_W'(59)) ? '0 : minB + BIN_W'(1)) : minB;

    nHour  = hourB;
    nPm    = pmQ;
    dayInc = 1'b0;
    if (hourInc) begin
      if (cmd.mode24) begin
        if (hourB >= BIN_W'(23)) begin
          nHour  = '0;
          dayInc = 1'b1;
        end else begin
          nHour = hourB + BIN_W'(1);
        end
      end else if (hourB == BIN_W'(11)) begin
        nHour  = BIN_W'(12);
        nPm    = !pmQ;
        dayInc = pmQ;
      end else if (hourB >= BIN_W'(12)) begin
        nHour = BIN_W'(1);
      end else begin
        nHour = hourB + BIN_W'(1);
      end
    end

    dayLimit = monthLen(monB, yearB[1:0]);
    monInc   = dayInc && (dayB >= dayLimit);
    nDay     = dayInc ? ((dayB >= dayLimit) ? BIN_W'(1) : dayB + BIN_W'(1)) : dayB;
    nWd      = dayInc ? ((wdB >= BIN_W'(6)) ? '0 : wdB + BIN_W'(1)) : wdB;

    yearInc = monInc && (monB >= BIN_W'(12));
    nMon    = monInc ? ((monB >= BIN_W'(12)) ? BIN_W'(1) : monB + BIN_W'(1)) : monB;
    nYear   = yearInc ? ((yearB >= BIN_W'(99)) ? '0 : yearB + BIN_W'(1)) : yearB;

    bcdSec  = binToBcd(nSec);
    bcdMin  = binToBcd(nMin);
    bcdHour = binToBcd(nHour);
    bcdDay  = binToBcd(nDay);
    bcdMon  = binToBcd(nMon);
    bcdYear = binToBcd(nYear);

    digitNext[IDX_SEC_U] = bcdSec[NIB_W-1:0];
    digitNext[IDX_SEC_T] = bcdSec[2*NIB_W-1:NIB_W];
    digitNext[IDX_MIN_U] = bcdMin[NIB_W-1:0];
    digitNext[IDX_MIN_T] = bcdMin[2*NIB_W-1:NIB_W];
    digitNext[IDX_HR_U]  = bcdHour[NIB_W-1:0];
    digitNext[IDX_HR_T]  = (bcdHour[2*NIB_W-1:NIB_W] & NIB_W'(3)) | {1'b0, nPm, 2'b00};
    digitNext[IDX_DAY_U] = bcdDay[NIB_W-1:0];
    digitNext[IDX_DAY_T] = bcdDay[2*NIB_W-1:NIB_W];
    digitNext[IDX_MON_U] = bcdMon[NIB_W-1:0];
    digitNext[IDX_MON_T] = bcdMon[2*NIB_W-1:NIB_W];
    digitNext[IDX_YR_U]  = bcdYear[NIB_W-1:0];
    digitNext[IDX_YR_T]  = bcdYear[2*NIB_W-1:NIB_W];
    digitNext[IDX_WDAY]  = nWd[NIB_W-1:0];
  end

  // one register per digit: seconds clear > host write > count
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    localparam bit IS_SEC = (i == IDX_SEC_U) || (i == IDX_SEC_T);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        digitQ[i] <= digitResetVal(i);
      end else if (IS_SEC && cmd.clearSec) begin
        digitQ[i] <= '0;
      end else if (cmd.wrDigit && cmd.wrAddr == ADDR_W'(i)) begin
        digitQ[i] <= cmd.wrData & digitMask(i);
      end else if (cmd.advance || cmd.round30) begin
        digitQ[i] <= digitNext[i] & digitMask(i);
      end
    end
  end

  for (genvar j = 0; j < NUM_REGS; j++) begin : g_rd
    if (j < NUM_DIGITS) begin : g_live
      assign rdVec[j] = digitQ[j];
    end else begin : g_none
      assign rdVec[j] = '0;
    end
  end

  assign digitRd = rdVec[rdAddr];
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSec,
  input  logic              tick64,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [NIB_W-1:0]  busWrData,
  output logic [NIB_W-1:0]  busRdData,
  output logic              irqOut
);
  dpCmd_t           dpCmd;
  dpStat_t          dpStat;
  logic [NIB_W-1:0] ctrlRd, digitRd;

  bcd_rtc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickSec   (tickSec),
    .tick64    (tick64),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .stat      (dpStat),
    .cmd       (dpCmd),
    .ctrlRd    (ctrlRd),
    .irqOut    (irqOut)
  );

  bcd_rtc_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (dpCmd),
    .rdAddr  (busAddr),
    .digitRd (digitRd),
    .stat    (dpStat)
  );

  assign busRdData = (busAddr < ADDR_W'(NUM_DIGITS)) ? digitRd : ctrlRd;
endmodule

// File: rtl/bcd_rtc_checker.sv
module bcd_rtc_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] busAddr,
  input logic       busWrEn,
  input logic [3:0] busWrData,
  input logic [3:0] busRdData,
  input logic       irqOut,
  input logic       advance,
  input logic       wrDigit
);
  assert_freeze_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 4'hD && busWrData[0]) |=> !advance);

  assert_write_defers_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrDigit |-> !advance);

  assert_busy_visible_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 4'hD) |-> (busRdData[1] == advance));

  assert_stop_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 4'hF && (busWrData[1] || busWrData[0])) |=> !advance);

  assert_mask_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 4'hE && busWrData[0]) |=> !irqOut);

  assert_sec_tens_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 4'h1) |-> !busRdData[3]);
endmodule

bind bcd_rtc bcd_rtc_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .irqOut    (irqOut),
  .advance   (dpCmd.advance),
  .wrDigit   (dpCmd.wrDigit)
);

// File: tb/tb_bcd_rtc.sv
`timescale 1ns/1ps
module tb_bcd_rtc;
  logic       clk = 1'b0;
  logic       rstN, tickSec, tick64, busWrEn;
  logic [3:0] busAddr, busWrData;
  wire  [3:0] busRdData;
  wire        irqOut;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  bcd_rtc dut (
    .clk(clk), .rstN(rstN), .tickSec(tickSec), .tick64(tick64),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic expectReg(input string tag, input logic [3:0] a, input logic [3:0] exp);
    @(negedge clk);
    busAddr = a;
    #2;
    check(tag, busRdData, exp);
  endtask

  task automatic tick();
    @(negedge clk); tickSec = 1'b1;
    @(negedge clk); tickSec = 1'b0;
  endtask

  task automatic sampleIrq(input string tag, input logic exp);
    #2;
    check(tag, {3'b000, irqOut}, {3'b000, exp});
  endtask

  task automatic setTime(input logic [3:0] hT, hU, mT, mU, sT, sU);
    wr(4'h5, hT); wr(4'h4, hU); wr(4'h3, mT); wr(4'h2, mU); wr(4'h1, sT); wr(4'h0, sU);
  endtask

  task automatic setDate(input logic [3:0] dT, dU, moT, moU, yT, yU, wd);
    wr(4'h7, dT); wr(4'h6, dU); wr(4'h9, moT); wr(4'h8, moU);
    wr(4'hB, yT); wr(4'hA, yU); wr(4'hC, wd);
  endtask

  task automatic checkTime(input string tag, input logic [3:0] hT, hU, mT, mU, sT, sU);
    expectReg({tag, " hour tens"}, 4'h5, hT);
    expectReg({tag, " hour units"}, 4'h4, hU);
    expectReg({tag, " min tens"}, 4'h3, mT);
    expectReg({tag, " min units"}, 4'h2, mU);
    expectReg({tag, " sec tens"}, 4'h1, sT);
    expectReg({tag, " sec units"}, 4'h0, sU);
  endtask

  task automatic checkDate(input string tag, input logic [3:0] dT, dU, moT, moU, yT, yU);
    expectReg({tag, " day tens"}, 4'h7, dT);
    expectReg({tag, " day units"}, 4'h6, dU);
    expectReg({tag, " month tens"}, 4'h9, moT);
    expectReg({tag, " month units"}, 4'h8, moU);
    expectReg({tag, " year tens"}, 4'hB, yT);
    expectReg({tag, " year units"}, 4'hA, yU);
  endtask

  task automatic testReset();
    logic [3:0] exp [16] = '{0,0,0,0,0,0,1,0,1,0,0,0,0,0,1,4};
    for (int i = 0; i < 16; i++) expectReg("R1 reset value", 4'(i), exp[i]);
  endtask

  task automatic testMasks();
    logic [3:0] mask [13] = '{4'hF,4'h7,4'hF,4'h7,4'hF,4'h7,4'hF,4'h3,4'hF,4'h1,4'hF,4'hF,4'h7};
    for (int i = 0; i < 13; i++) begin
      wr(4'(i), 4'hF);
      expectReg("R2 masked readback", 4'(i), mask[i]);
    end
    wr(4'hD, 4'h0);
    expectReg("R2 status bit3 reads 0", 4'hD, 4'h0);
    setTime(0,0,0,0,0,0);
    setDate(0,1,0,1,0,0,0);
  endtask

  task automatic testChain();
    setTime(0,0,0,0,0,9);
    tick();
    checkTime("R3 units wrap", 0,0,0,0,1,0);
    setTime(0,1,5,9,5,8);
    tick();
    checkTime("R3 to 59", 0,1,5,9,5,9);
    tick();
    checkTime("R3 minute and hour carry", 0,2,0,0,0,0);
  endtask

  task automatic test24();
    setTime(2,3,5,9,5,9);
    setDate(1,5,0,3,2,1,6);
    tick();
    checkTime("R4 midnight", 0,0,0,0,0,0);
    checkDate("R4 day advance", 1,6,0,3,2,1);
    expectReg("R4 weekday wrap", 4'hC, 4'h0);
  endtask

  task automatic test12();
    wr(4'hF, 4'h0);
    setTime(1,1,5,9,5,9);
    setDate(1,0,0,5,2,1,3);
    tick();
    checkTime("R5 11AM to 12PM", 5,2,0,0,0,0);
    expectReg("R5 no day change at noon", 4'h6, 4'h0);
    setTime(5,2,5,9,5,9);
    tick();
    checkTime("R5 12PM to 1PM", 4,1,0,0,0,0);
    setTime(5,1,5,9,5,9);
    tick();
    checkTime("R5 11PM to 12AM", 1,2,0,0,0,0);
    checkDate("R5 day at midnight", 1,1,0,5,2,1);
    expectReg("R5 weekday step", 4'hC, 4'h4);
    wr(4'hF, 4'h4);
  endtask

  task automatic monthCase(input string tag, input logic [3:0] dT, dU, moT, moU, yT, yU,
                           input logic [3:0] edT, edU, emoT, emoU, eyT, eyU);
    setTime(2,3,5,9,5,9);
    setDate(dT, dU, moT, moU, yT, yU, 4'h2);
    tick();
    checkDate(tag, edT, edU, emoT, emoU, eyT, eyU);
  endtask

  task automatic testMonths();
    monthCase("R6 30-day month", 3,0,0,4,2,1, 0,1,0,5,2,1);
    monthCase("R6 Feb non-leap", 2,8,0,2,2,1, 0,1,0,3,2,1);
    monthCase("R6 Feb leap", 2,8,0,2,2,4, 2,9,0,2,2,4);
    monthCase("R6 31-day month", 3,0,0,1,2,1, 3,1,0,1,2,1);
    monthCase("R6 year wrap", 3,1,1,2,9,9, 0,1,0,1,0,0);
  endtask

  task automatic testHold();
    setTime(0,0,0,0,1,0);
    wr(4'hD, 4'h1);
    tick(); tick(); tick();
    expectReg("R7 frozen seconds", 4'h0, 4'h0);
    expectReg("R7 hold bit", 4'hD, 4'h1);
    wr(4'hD, 4'h0);
    @(negedge clk);
    @(negedge clk);
    checkTime("R7 single pending advance", 0,0,0,0,1,1);
  endtask

  task automatic testBusy();
    setTime(0,0,0,0,0,0);
    @(negedge clk); busAddr = 4'hD; tickSec = 1'b1;
    #2 check("R8 busy during apply", {3'b000, busRdData[1]}, 4'h1);
    @(negedge clk); tickSec = 1'b0;
    #2 check("R8 busy idle", {3'b000, busRdData[1]}, 4'h0);
    expectReg("R8 applied second", 4'h0, 4'h1);
    wr(4'hD, 4'h1);
    @(negedge clk); busAddr = 4'hD; tickSec = 1'b1;
    #2 check("R8 no busy while frozen", {3'b000, busRdData[1]}, 4'h0);
    @(negedge clk); tickSec = 1'b0;
    wr(4'hD, 4'h0);
    @(negedge clk);
    expectReg("R8 frozen tick applied later", 4'h0, 4'h2);
    @(negedge clk);
    busAddr = 4'h2; busWrData = 4'h5; busWrEn = 1'b1; tickSec = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; tickSec = 1'b0; busAddr = 4'h0;
    #2 check("R8 tick deferred by write", busRdData, 4'h2);
    expectReg("R8 deferred tick applied", 4'h0, 4'h3);
    expectReg("R8 written minute", 4'h2, 4'h5);
  endtask

  task automatic testAdjust();
    setTime(0,0,1,0,4,5);
    wr(4'hD, 4'h8);
    checkTime("R9 round up", 0,0,1,1,0,0);
    expectReg("R9 adjust bit self-clears", 4'hD, 4'h0);
    setTime(0,0,1,0,2,9);
    wr(4'hD, 4'h8);
    checkTime("R9 round down", 0,0,1,0,0,0);
  endtask

  task automatic testStopReset();
    setTime(0,0,0,3,4,2);
    wr(4'hF, 4'h6);
    tick(); tick();
    checkTime("R10 stopped", 0,0,0,3,4,2);
    wr(4'hF, 4'h4);
    @(negedge clk); @(negedge clk);
    expectReg("R10 nothing remembered from stop", 4'h0, 4'h2);
    wr(4'hF, 4'h5);
    tick();
    checkTime("R10 reset holds seconds", 0,0,0,3,0,0);
    wr(4'h0, 4'h7);
    expectReg("R10 second write ignored in reset", 4'h0, 4'h0);
    wr(4'hF, 4'h4);
  endtask

  task automatic testIrq();
    wr(4'hE, 4'b0110);
    wr(4'hD, 4'h0);
    sampleIrq("R12 latched idle", 1'b0);
    tick();
    sampleIrq("R12 latched set by second", 1'b1);
    expectReg("R11 flag set", 4'hD, 4'h4);
    wr(4'hD, 4'h4);
    expectReg("R11 write 1 keeps flag", 4'hD, 4'h4);
    wr(4'hD, 4'h0);
    sampleIrq("R11 flag cleared", 1'b0);

    wr(4'hE, 4'b1010);
    setTime(0,0,0,0,5,8);
    tick();
    sampleIrq("R11 minute rate no early fire", 1'b0);
    tick();
    sampleIrq("R11 minute rate fires", 1'b1);
    wr(4'hD, 4'h0);

    wr(4'hE, 4'b1110);
    setTime(0,0,1,0,5,9);
    tick();
    sampleIrq("R11 hour rate ignores minute", 1'b0);
    setTime(0,0,5,9,5,9);
    tick();
    sampleIrq("R11 hour rate fires", 1'b1);
    wr(4'hD, 4'h0);

    wr(4'hE, 4'b0010);
    tick();
    sampleIrq("R11 64Hz rate ignores second", 1'b0);
    @(negedge clk); tick64 = 1'b1;
    @(negedge clk); tick64 = 1'b0;
    sampleIrq("R11 64Hz rate fires", 1'b1);
    wr(4'hD, 4'h0);

    wr(4'hE, 4'b0111);
    tick();
    sampleIrq("R12 masked output", 1'b0);
    expectReg("R12 flag set under mask", 4'hD, 4'h4);
    wr(4'hD, 4'h0);

    wr(4'hE, 4'b0100);
    sampleIrq("R12 pulse idle", 1'b0);
    tick();
    sampleIrq("R12 pulse high", 1'b1);
    @(negedge clk);
    sampleIrq("R12 pulse one cycle", 1'b0);
  endtask

  initial begin
    rstN = 1'b0; tickSec = 1'b0; tick64 = 1'b0;
    busAddr = 4'h0; busWrEn = 1'b0; busWrData = 4'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMasks();
    testChain();
    test24();
    test12();
    testMonths();
    testHold();
    testBusy();
    testAdjust();
    testStopReset();
    testIrq();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule